// File: doc/BRIEF.md
# Status Register and Write-Guard Unit

This unit holds the eight-bit status word of a serial memory with a supervisor function and decides, cycle by cycle, whether the array location on `tgt_addr` may be written and whether a status write may be accepted. The command engine supplies the write-enable latch (`wel_in`) and the busy indication (`wip_in`). Both appear unchanged in the two low status bits. The engine also issues status-write requests, flag strobes and the target address. The unit returns the status byte, two permission flags and the watchdog period select.

A status write is taken only when permitted. The new lock-enable, watchdog and block-lock values are then held pending and become visible on the clock edge that sees `wip_in` fall. A write that has already been taken therefore completes even if the external guard pin drops while it is in flight. The guard pin is resynchronised through a two-flop chain. The lock-enable, watchdog and block-lock bits come up from reset with fixed defaults.

Top module: `sr_protect`

## Requirements
- R1: After reset the status byte reads 0x30 when `wel_in` and `wip_in` are 0. Lock-enable (bit 7) is 0, the flag (bit 6) is 0, watchdog select (bits 5:4) is 11 and block-lock (bits 3:2) is 00.
- R2: While `wel_in` is 0, both `arr_wr_ok` and `stat_wr_ok` are 0, and a status-write request leaves the status byte unchanged.
- R3: With `wel_in` at 1, `arr_wr_ok` is 0 exactly when the address is in the protected region. The region is selected by block-lock: 00 protects nothing, 01 protects the top quarter (address bits 11:10 = 11), 10 protects the top half (bit 11 = 1), and 11 protects every address. Lock-enable and the guard pin have no effect on `arr_wr_ok`.
- R4: When lock-enable is 1 and the synchronised guard pin is low, `stat_wr_ok` is 0 and status-write requests are ignored. Otherwise `stat_wr_ok` equals `wel_in`.
- R5: An accepted status write captures data bits 7 and 5:2. These appear in the status byte on the clock edge where `wip_in` is sampled 0 after being 1, and the status byte keeps its old value until then.
- R6: In a status write, data bits 6, 1 and 0 have no effect. Status bits 1:0 always equal {`wel_in`, `wip_in`}.
- R7: A status write accepted before the guard pin falls still completes when `wip_in` falls, even if the lock has engaged by then.
- R8: `flag_set` sets status bit 6 and `flag_clr` clears it on the next edge. If both are asserted in the same cycle, the clear wins.
- R9: A change on `prot_pin` reaches `stat_wr_ok` after exactly two rising clock edges.
- R10: `wd_sel` always equals status bits 5:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prot_pin | input | 1 | External guard pin; low arms the lock when lock-enable is 1 |
| wel_in | input | 1 | Write-enable latch from the command engine |
| wip_in | input | 1 | Nonvolatile write cycle busy from the command engine |
| sw_req | input | 1 | Status-write request, one cycle |
| sw_data | input | 8 | Status-write data byte |
| flag_set | input | 1 | Set-flag strobe |
| flag_clr | input | 1 | Clear-flag strobe |
| tgt_addr | input | ADDR_W | Array address under test |
| status | output | 8 | Status byte |
| arr_wr_ok | output | 1 | Array write to `tgt_addr` permitted |
| stat_wr_ok | output | 1 | Status write permitted |
| wd_sel | output | 2 | Watchdog period select |

## Verification
The address decode is tested with a table of block-lock codes and addresses. The addresses are placed on each side of the quarter and half boundaries, so an off-by-one region or a swapped code shows up as a wrong permission. A separate sequence commits a status write while the guard pin falls mid-cycle. This separates correct completion from a design that aborts in-flight writes. Once the lock has engaged, a second request is ignored. Other sequences vary the pin timing edge by edge to pin the synchroniser depth, and fire set and clear strobes together to fix the flag priority.

// File: rtl/sr_protect.sv
module sr_protect #(
  parameter int ADDR_W = 12,
  parameter int SYNC_N = 2,
  parameter logic [1:0] WD_DEF = 2'b11,
  parameter logic [1:0] BL_DEF = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_pin,
  input  logic              wel_in,
  input  logic              wip_in,
  input  logic              sw_req,
  input  logic [7:0]        sw_data,
  input  logic              flag_set,
  input  logic              flag_clr,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic [7:0]        status,
  output logic              arr_wr_ok,
  output logic              stat_wr_ok,
  output logic [1:0]        wd_sel
);

  logic [SYNC_N-1:0] pin_sync;
  logic              pin_s;
  logic              wpen, flag, pend, wip_q;
  logic [1:0]        wd, bl;
  logic [4:0]        pend_val;
  logic [1:0]        top;
  logic              hit, locked, take, commit;

  assign pin_s  = pin_sync[SYNC_N-1];
  assign locked = wpen & ~pin_s;
  assign top    = tgt_addr[ADDR_W-1 -: 2];

  always_comb begin
    case (bl)
      2'b00:   hit = 1'b0;
      2'b01:   hit = &top;
      2'b10:   hit = top[1];
      default: hit = 1'b1;
    endcase
  end

  assign arr_wr_ok  = wel_in & ~hit;
  assign stat_wr_ok = wel_in & ~locked;
  assign take       = sw_req & stat_wr_ok & ~pend;
  assign commit     = pend & wip_q & ~wip_in;
  assign status     = {wpen, flag, wd, bl, wel_in, wip_in};
  assign wd_sel     = wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_sync <= '1;
    else        pin_sync <= {pin_sync[SYNC_N-2:0], prot_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q    <= 1'b0;
      pend     <= 1'b0;
      pend_val <= '0;
      wpen     <= 1'b0;
      wd       <= WD_DEF;
      bl       <= BL_DEF;
    end else begin
      wip_q <= wip_in;
      if (take) begin
        pend     <= 1'b1;
        pend_val <= {sw_data[7], sw_data[5:2]};
      end else if (commit) begin
        pend <= 1'b0;
        wpen <= pend_val[4];
        wd   <= pend_val[3:2];
        bl   <= pend_val[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (flag_clr) flag <= 1'b0;
    else if (flag_set) flag <= 1'b1;
  end

endmodule

// File: rtl/sr_protect_chk.sv
module sr_protect_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wel_in,
  input logic              wip_in,
  input logic              flag_set,
  input logic              flag_clr,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic [7:0]        status,
  input logic              arr_wr_ok,
  input logic              stat_wr_ok,
  input logic [1:0]        wd_sel
);

  a_r2_no_wel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wel_in |-> (!arr_wr_ok && !stat_wr_ok));

  a_r3_full_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'b11) |-> !arr_wr_ok);

  a_r3_quarter_low_open: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'b01 && tgt_addr[ADDR_W-1 -: 2] != 2'b11 && wel_in) |-> arr_wr_ok);

  a_r5_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(wip_in) |=> $stable({status[7], status[5:2]}));

  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set && !flag_clr) |=> status[6]);

  a_r8_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !status[6]);

  a_r10_wd_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(wd_sel) |-> $changed(status[5:4]));

endmodule

bind sr_protect sr_protect_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wel_in(wel_in), .wip_in(wip_in),
  .flag_set(flag_set), .flag_clr(flag_clr), .tgt_addr(tgt_addr),
  .status(status), .arr_wr_ok(arr_wr_ok), .stat_wr_ok(stat_wr_ok), .wd_sel(wd_sel)
);

// File: tb/sim_sr_protect.sv
module sim_sr_protect;
  logic clk = 1'b0, rst_n = 1'b0;
  logic prot_pin = 1'b1, wel_in = 1'b0, wip_in = 1'b0, sw_req = 1'b0;
  logic [7:0] sw_data = '0;
  logic flag_set = 1'b0, flag_clr = 1'b0;
  logic [11:0] tgt_addr = '0;
  logic [7:0] status;
  logic arr_wr_ok, stat_wr_ok;
  logic [1:0] wd_sel;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  sr_protect u0 (.clk(clk), .rst_n(rst_n), .prot_pin(prot_pin), .wel_in(wel_in),
    .wip_in(wip_in), .sw_req(sw_req), .sw_data(sw_data), .flag_set(flag_set),
    .flag_clr(flag_clr), .tgt_addr(tgt_addr), .status(status),
    .arr_wr_ok(arr_wr_ok), .stat_wr_ok(stat_wr_ok), .wd_sel(wd_sel));

  // {block-lock, address, expected arr_wr_ok}
  localparam logic [14:0] VEC [12] = '{
    {2'b00, 12'hFFF, 1'b1}, {2'b01, 12'hBFF, 1'b1}, {2'b01, 12'hC00, 1'b0},
    {2'b01, 12'hFFF, 1'b0}, {2'b10, 12'h7FF, 1'b1}, {2'b10, 12'h800, 1'b0},
    {2'b10, 12'hBFF, 1'b0}, {2'b11, 12'h000, 1'b0}, {2'b11, 12'h7FF, 1'b0},
    {2'b00, 12'h000, 1'b1}, {2'b01, 12'h000, 1'b1}, {2'b10, 12'h000, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    sw_data = d; sw_req = 1'b1;
    @(negedge clk); sw_req = 1'b0; wip_in = 1'b1;
    @(negedge clk); wip_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status, 8'h30);
    chk("R10 reset wd_sel", {6'b0, wd_sel}, 8'h03);
    chk("R2 no wel", {6'b0, arr_wr_ok, stat_wr_ok}, 8'h00);
    do_write(8'h8C);
    chk("R2 request without wel ignored", status, 8'h30);

    wel_in = 1'b1;
    for (int i = 0; i < 12; i++) begin
      do_write({4'b0011, VEC[i][14:13], 2'b00});
      tgt_addr = VEC[i][12:1];
      #1;
      chk($sformatf("R3 vec%0d bl", i), {6'b0, status[3:2]}, {6'b0, VEC[i][14:13]});
      chk($sformatf("R3 vec%0d arr_wr_ok", i), {7'b0, arr_wr_ok}, {7'b0, VEC[i][0]});
    end

    sw_data = 8'h97; sw_req = 1'b1;
    @(negedge clk); sw_req = 1'b0; wip_in = 1'b1;
    @(negedge clk);
    chk("R5 held before done", {status[7], status[5:2], 3'b0}, {1'b0, 4'b1110, 3'b0});
    wip_in = 1'b0;
    @(negedge clk);
    chk("R5 R6 committed", status, 8'h96);
    chk("R10 wd_sel follows", {6'b0, wd_sel}, 8'h01);
    chk("R4 open with pin high", {7'b0, stat_wr_ok}, 8'h01);
    tgt_addr = 12'h800;
    #1 chk("R3 pin and wpen do not affect array", {7'b0, arr_wr_ok}, 8'h01);

    sw_data = 8'hAC; sw_req = 1'b1;
    @(negedge clk); sw_req = 1'b0; wip_in = 1'b1; prot_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 lock engaged", {7'b0, stat_wr_ok}, 8'h00);
    wip_in = 1'b0;
    @(negedge clk);
    chk("R7 in-flight write completes", status, 8'hAE);

    do_write(8'h00);
    chk("R4 locked request ignored", status, 8'hAE);

    prot_pin = 1'b1;
    @(negedge clk);
    chk("R9 one edge not enough", {7'b0, stat_wr_ok}, 8'h00);
    @(negedge clk);
    chk("R9 two edges", {7'b0, stat_wr_ok}, 8'h01);

    flag_set = 1'b1;
    @(negedge clk); flag_set = 1'b0;
    chk("R8 flag set", {7'b0, status[6]}, 8'h01);
    do_write(8'h03);
    chk("R6 data bits 6 1 0 ignored", status, 8'h42);
    flag_set = 1'b1; flag_clr = 1'b1;
    @(negedge clk); flag_set = 1'b0; flag_clr = 1'b0;
    chk("R8 clear wins", {7'b0, status[6]}, 8'h00);
    flag_set = 1'b1;
    @(negedge clk); flag_set = 1'b0; flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R8 flag clear", {7'b0, status[6]}, 8'h00);

    wel_in = 1'b0; wip_in = 1'b1;
    #1 chk("R6 low bits track engine", {6'b0, status[1:0]}, 8'h01);
    wip_in = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule